// File: doc/BRIEF.md
# Serial-Loaded Two-Grid Display Multiplexer

This block receives display frames from a host controller over a three-wire serial link made of an active-low select, a serial clock and a data line. Each frame holds a 3-bit function code and a 34-bit display word. The bits arrive least significant first, and the function code is sent before the display word. All three serial lines are synchronised into the system clock domain. Serial clock edges count only while select is low, so the clock and data lines can be shared with other devices.

When select returns high after a frame of exactly 37 bits whose function code is display load, the display word moves into a holding register. A scan state machine then time-shares that register across 17 segment outputs under two grid enables at half duty. Holding bits 1 to 17 appear during the grid 1 phase, and bits 18 to 34 appear during the grid 2 phase. A short blank gap separates every grid change. Frames carrying the keyscan or converter-readback code raise a one-cycle request strobe instead of touching the display.

The scan machine has five states, with the following transitions:
- OFF goes to GRID1 on the first valid load.
- GRID1 goes to BLANK_A after `phase_len` cycles.
- BLANK_A goes to GRID2 after `BLANK_CYC` cycles.
- GRID2 goes to BLANK_B after `phase_len` cycles.
- BLANK_B goes back to GRID1 after `BLANK_CYC` cycles.

Top module: `vfd_duplex_ctrl`

## Requirements
- R1: After reset both grid enables and all segment outputs are 0, and they stay 0 until the first valid display load.
- R2: A frame of exactly 37 serial bits is sampled on serial clock rising edges, least significant bit first. Frame bits 0..2 form the function code, and frame bits 3..36 become holding bits 1..34. If the code is 3'b001 (display load), the holding register takes the display word when `cs_n` rises.
- R3: A frame with any bit count other than 37 leaves the holding register and the display unchanged.
- R4: Frames whose function code is not 3'b001 leave the holding register and the display unchanged.
- R5: The keyscan code 3'b010 raises `key_req` for exactly one cycle per frame, and the converter code 3'b100 raises `adc_req` for exactly one cycle per frame. The two strobes are never high together.
- R6: Serial clock and data activity while `cs_n` is high is ignored.
- R7: While grid 1 is active, `seg` shows holding bits 1..17 (bit 1 on `seg[0]`). While grid 2 is active, `seg` shows holding bits 18..34.
- R8: The two grid enables are never active together, and they alternate.
- R9: Each grid phase lasts `phase_len` system clocks (0 acts as 1). It is followed by `BLANK_CYC` clocks in which both grids and all segments are 0.
- R10: The first grid to light after the first valid load is grid 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, sampled on rising edge |
| sdi | input | 1 | Serial data from host |
| phase_len | input | 16 | Grid phase length in system clocks |
| grid1 | output | 1 | Grid 1 enable |
| grid2 | output | 1 | Grid 2 enable |
| seg | output | 17 | Segment enables |
| key_req | output | 1 | One-cycle keyscan readback request |
| adc_req | output | 1 | One-cycle converter readback request |

## Verification
The bench sends frames of 36 and 38 bits. A design that does not compare the bit count exactly would corrupt the display with a shifted word. It also toggles the serial clock with select high. A receiver that shifts without qualification would miscount the following frame and drop it. Segment values are compared separately under each grid, which catches swapped or misaligned halves. The bench times phase and blank lengths at two `phase_len` settings, which catches off-by-one dividers and a missing blank gap. Non-display codes are checked for both an unchanged display and single-cycle request strobes.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
    localparam logic [2:0] FN_DISP = 3'b001;
    localparam logic [2:0] FN_KEY  = 3'b010;
    localparam logic [2:0] FN_ADC  = 3'b100;

    typedef enum logic [2:0] {
        SC_OFF,
        SC_GRID1,
        SC_BLANK_A,
        SC_GRID2,
        SC_BLANK_B
    } scan_st_t;
endpackage

// File: rtl/vfd_serial_rx.sv
module vfd_serial_rx
    import vfd_pkg::*;
#(
    parameter int MODE_W = 3,
    parameter int DATA_W = 34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              frame_ok,
    output logic [DATA_W-1:0] frame_data,
    output logic              key_req,
    output logic              adc_req
);
    localparam int FRAME_BITS = MODE_W + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);

    logic [1:0] cs_sy, ck_sy, dt_sy;
    logic       ck_d, cs_d;
    logic [FRAME_BITS-1:0] sr;
    logic [CNT_W-1:0]      cnt;
    logic [MODE_W-1:0]     mode_nxt;
    logic shift_en, cs_rel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_sy <= 2'b11;
            ck_sy <= 2'b00;
            dt_sy <= 2'b00;
            ck_d  <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            cs_sy <= {cs_sy[0], cs_n};
            ck_sy <= {ck_sy[0], sclk};
            dt_sy <= {dt_sy[0], sdi};
            ck_d  <= ck_sy[1];
            cs_d  <= cs_sy[1];
        end
    end

    assign shift_en = ck_sy[1] && !ck_d && !cs_sy[1];
    assign cs_rel   = cs_sy[1] && !cs_d;
    assign mode_nxt = {dt_sy[1], sr[FRAME_BITS-1 -: MODE_W-1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr      <= '0;
            cnt     <= '0;
            key_req <= 1'b0;
            adc_req <= 1'b0;
        end else begin
            key_req <= 1'b0;
            adc_req <= 1'b0;
            if (cs_rel) begin
                cnt <= '0;
            end else if (shift_en) begin
                sr <= {dt_sy[1], sr[FRAME_BITS-1:1]};
                if (cnt != '1) cnt <= cnt + 1'b1;
                if (cnt == CNT_W'(MODE_W - 1)) begin
                    key_req <= (mode_nxt == FN_KEY);
                    adc_req <= (mode_nxt == FN_ADC);
                end
            end
        end
    end

    assign frame_ok   = cs_rel && (cnt == CNT_W'(FRAME_BITS)) && (sr[MODE_W-1:0] == FN_DISP);
    assign frame_data = sr[FRAME_BITS-1:MODE_W];

    AST_RX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_sy[1] |=> $stable(sr)); // R6
    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(key_req && adc_req)); // R5
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        key_req |=> !key_req); // R5
endmodule

// File: rtl/vfd_scan.sv
module vfd_scan
    import vfd_pkg::*;
#(
    parameter int SEG_N     = 17,
    parameter int PH_W      = 16,
    parameter int BLANK_CYC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [PH_W-1:0]    phase_len,
    input  logic [2*SEG_N-1:0] hold,
    output logic               grid1,
    output logic               grid2,
    output logic [SEG_N-1:0]   seg
);
    localparam logic [PH_W-1:0] BLANK_LAST = PH_W'(BLANK_CYC - 1);

    scan_st_t        st, st_nxt;
    logic [PH_W-1:0] cnt, cnt_nxt, ph_last;

    assign ph_last = (phase_len == '0) ? '0 : phase_len - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= SC_OFF;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end

    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt + 1'b1;
        unique case (st)
            SC_OFF: begin
                cnt_nxt = '0;
                if (en) st_nxt = SC_GRID1;
            end
            SC_GRID1: if (cnt >= ph_last) begin
                st_nxt  = SC_BLANK_A;
                cnt_nxt = '0;
            end
            SC_BLANK_A: if (cnt >= BLANK_LAST) begin
                st_nxt  = SC_GRID2;
                cnt_nxt = '0;
            end
            SC_GRID2: if (cnt >= ph_last) begin
                st_nxt  = SC_BLANK_B;
                cnt_nxt = '0;
            end
            SC_BLANK_B: if (cnt >= BLANK_LAST) begin
                st_nxt  = SC_GRID1;
                cnt_nxt = '0;
            end
            default: begin
                st_nxt  = SC_OFF;
                cnt_nxt = '0;
            end
        endcase
    end

    always_comb begin
        grid1 = 1'b0;
        grid2 = 1'b0;
        seg   = '0;
        unique case (st)
            SC_GRID1: begin
                grid1 = 1'b1;
                seg   = hold[SEG_N-1:0];
            end
            SC_GRID2: begin
                grid2 = 1'b1;
                seg   = hold[2*SEG_N-1:SEG_N];
            end
            default: ;
        endcase
    end

    AST_GRID_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(grid1 && grid2)); // R8
    AST_BLANK_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        (!grid1 && !grid2) |-> (seg == '0)); // R9
    AST_G2_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grid2) |-> !$past(grid1)); // R9
endmodule

// File: rtl/vfd_duplex_ctrl.sv
module vfd_duplex_ctrl
    import vfd_pkg::*;
#(
    parameter int SEG_N     = 17,
    parameter int MODE_W    = 3,
    parameter int PH_W      = 16,
    parameter int BLANK_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             sdi,
    input  logic [PH_W-1:0]  phase_len,
    output logic             grid1,
    output logic             grid2,
    output logic [SEG_N-1:0] seg,
    output logic             key_req,
    output logic             adc_req
);
    localparam int DATA_W = 2 * SEG_N;

    logic              frame_ok;
    logic [DATA_W-1:0] frame_data;
    logic [DATA_W-1:0] hold;
    logic              disp_en;

    vfd_serial_rx #(.MODE_W(MODE_W), .DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .frame_ok(frame_ok), .frame_data(frame_data),
        .key_req(key_req), .adc_req(adc_req)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold    <= '0;
            disp_en <= 1'b0;
        end else if (frame_ok) begin
            hold    <= frame_data;
            disp_en <= 1'b1;
        end
    end

    vfd_scan #(.SEG_N(SEG_N), .PH_W(PH_W), .BLANK_CYC(BLANK_CYC)) u_scan (
        .clk(clk), .rst_n(rst_n), .en(disp_en), .phase_len(phase_len),
        .hold(hold), .grid1(grid1), .grid2(grid2), .seg(seg)
    );

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_ok |=> $stable(hold)); // R3
    AST_DARK_UNTIL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |-> (!grid1 && !grid2 && seg == '0)); // R1
endmodule

// File: tb/vfd_duplex_ctrl_bench.sv
module vfd_duplex_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic [15:0] phase_len = 16'd20;
    logic        grid1, grid2, key_req, adc_req;
    logic [16:0] seg;
    int checks = 0, fails = 0, key_cnt = 0, adc_cnt = 0, cyc = 0;
    logic [33:0] exp_hold = '0;
    bit lit = 1'b0;

    always #4 clk = ~clk;

    vfd_duplex_ctrl u_vfd_duplex_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .phase_len(phase_len), .grid1(grid1), .grid2(grid2), .seg(seg),
        .key_req(key_req), .adc_req(adc_req)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (key_req) key_cnt <= key_cnt + 1;
        if (adc_req) adc_cnt <= adc_cnt + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not complete (actual %0d cycles, expected < 150000)", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
            $finish;
        end
    end

    // entry: {function code, display word, bit count, display changes}
    localparam logic [43:0] VEC [8] = '{
        {3'b001, 34'h2AAAA5555, 6'd37, 1'b1},
        {3'b010, 34'h1234ABCDE, 6'd37, 1'b0},
        {3'b001, 34'h0F0F0F0F0, 6'd36, 1'b0},
        {3'b001, 34'h0F0F0F0F0, 6'd38, 1'b0},
        {3'b100, 34'h3FFFFFFFF, 6'd37, 1'b0},
        {3'b111, 34'h000000000, 6'd37, 1'b0},
        {3'b001, 34'h00001FFFF, 6'd37, 1'b1},
        {3'b001, 34'h3FFFE0000, 6'd37, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic send(input logic [36:0] fr, input int nb);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            sdi = (i < 37) ? fr[i] : 1'b0;
            repeat (4) @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic stray(input int n);
        for (int i = 0; i < n; i++) begin
            sdi = i[0];
            repeat (3) @(negedge clk);
            sclk = 1'b1;
            repeat (3) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic wait_g(input bit which);
        int t = 0;
        while (((which ? grid2 : grid1) == 1'b1) && t < 4000) begin @(negedge clk); t++; end
        while (((which ? grid2 : grid1) == 1'b0) && t < 4000) begin @(negedge clk); t++; end
    endtask

    task automatic check_disp(input string req);
        wait_g(1'b0);
        chk(grid1 && !grid2 && seg == exp_hold[16:0], req, {grid1, grid2, seg}, {2'b10, exp_hold[16:0]});
        wait_g(1'b1);
        chk(grid2 && !grid1 && seg == exp_hold[33:17], req, {grid1, grid2, seg}, {2'b01, exp_hold[33:17]});
    endtask

    task automatic measure(input int ph);
        int n = 0, b = 0;
        bit segz = 1'b1;
        wait_g(1'b1);
        wait_g(1'b0);
        while (grid1) begin @(negedge clk); n++; end
        while (!grid1 && !grid2) begin
            if (seg != '0) segz = 1'b0;
            @(negedge clk); b++;
        end
        chk(n == ph, "R9 grid1 length", n, ph);
        chk(b == 2 && segz, "R9 blank gap", b, 2);
        chk(grid2, "R8 grid2 follows gap", grid2, 1);
        n = 0;
        while (grid2) begin @(negedge clk); n++; end
        chk(n == ph, "R9 grid2 length", n, ph);
    endtask

    initial begin
        int k0, a0;
        bit g1first;
        repeat (3) @(negedge clk);
        chk(!grid1 && !grid2 && seg == '0, "R1 reset", {grid1, grid2, seg}, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(!grid1 && !grid2 && seg == '0, "R1 dark after reset", {grid1, grid2, seg}, 0);
        stray(10);
        repeat (40) @(negedge clk);
        chk(!grid1 && !grid2 && seg == '0, "R6 idle clocks ignored", {grid1, grid2, seg}, 0);

        foreach (VEC[v]) begin
            logic [2:0]  md = VEC[v][43:41];
            logic [33:0] dw = VEC[v][40:7];
            int          nb = int'(VEC[v][6:1]);
            bit          chg = VEC[v][0];
            k0 = key_cnt;
            a0 = adc_cnt;
            send({dw, md}, nb);
            chk(key_cnt - k0 == ((md == 3'b010) ? 1 : 0), "R5 key_req pulses", key_cnt - k0, md == 3'b010);
            chk(adc_cnt - a0 == ((md == 3'b100) ? 1 : 0), "R5 adc_req pulses", adc_cnt - a0, md == 3'b100);
            if (chg) exp_hold = dw;
            if (chg && !lit) begin
                int t = 0;
                while (!grid1 && !grid2 && t < 100) begin @(negedge clk); t++; end
                g1first = grid1 && !grid2;
                chk(g1first, "R10 grid1 first", {grid1, grid2}, 2'b10);
                lit = 1'b1;
            end
            if (lit) check_disp(chg ? "R2/R7 load" : (nb != 37 ? "R3 bad count" : "R4 other code"));
            else chk(!grid1 && !grid2, "R1 still dark", {grid1, grid2}, 0);
        end

        stray(5);
        exp_hold = 34'h155555AAA;
        send({exp_hold, 3'b001}, 37);
        check_disp("R6 stray clocks then frame");

        measure(20);
        phase_len = 16'd7;
        measure(7);
        phase_len = 16'd0;
        measure(1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule